// File: doc/BRIEF.md
# Trigger Busy Shift and Extend

This block receives a trigger input and gives it two roles. The rising edge of the input becomes a single-cycle trigger pulse. The time the input stays high is read as the acquisition system's busy level. The busy level is delayed by a programmable number of clock cycles and then held high for a programmable number of extra cycles. This compensates for cable and processing delays before the result gates a bank of scalers. The block is built for a 5 ns clock, so one setting step equals 5 ns.

Two physical inputs can carry the trigger: a differential (LVDS) channel and a NIM channel. A select bit picks one of them. The selected input is registered once. That registered level feeds the edge detector and the busy path, so both roles see the same sample. The delay setting covers 0 to 500 cycles, which is 0 to 2500 ns. The extension setting covers 0 to 31 cycles, which is 0 to 155 ns. Software is expected to keep the extension no longer than the busy pulse. Configuration is meant to change only while the block is idle or in reset.

Top module: `trig_busy_gate`

## Requirements
- R1: At every clock edge the block samples the selected input into its level register. `sel_lvds` = 1 selects `src_lvds` and `sel_lvds` = 0 selects `src_nim`. Call that sample lvl[n] for edge n; it is 0 for every edge in reset.
- R2: `trig_pulse` is high in the cycle after edge n exactly when lvl[n] = 1 and lvl[n-1] = 0. It is never high for two cycles in a row.
- R3: With extension 0, `busy_gate` after edge n equals lvl[n-d], where d is `dly_set`. A setting of 0 passes the level with no added delay.
- R4: A `dly_set` value above 500 behaves exactly like 500.
- R5: `busy_gate` after edge n is high exactly when any of lvl[n-d-j] is 1 for j from 0 to e, where e is `ext_set`. The gate therefore stays high e cycles after the delayed level falls.
- R6: The input that is not selected has no effect on either output.
- R7: While `rst_n` is low, `trig_pulse` and `busy_gate` are low, and the delay line and the extension counter are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 5 ns per setting step |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvds | input | 1 | Trigger candidate from the differential channel |
| src_nim | input | 1 | Trigger candidate from the NIM channel |
| sel_lvds | input | 1 | 1 selects `src_lvds`, 0 selects `src_nim` |
| dly_set | input | 9 | Busy delay in cycles, values above 500 act as 500 |
| ext_set | input | 5 | Busy extension in cycles |
| trig_pulse | output | 1 | One-cycle pulse on the leading edge of the selected input |
| busy_gate | output | 1 | Delayed and extended busy level, used as the scaler gate |

## Verification
A wrong tap choice or a shift-register fault moves the whole gate in time. The error shows at `busy_gate` in the first cycle after the delayed level should have risen or fallen, which is d cycles after the input changes. A counter that loads or decrements wrongly shows only at a falling edge of the delayed level: the gate tail comes out longer or shorter than e cycles. A source-select or edge-detect fault shows at `trig_pulse` one cycle after the offending input sample. The bench sweeps delay values across the edges of the range, the clamp above 500, and several extension lengths on both sources. It compares every cycle of both outputs against a model computed from the sampled-level history.

// File: rtl/trig_busy_pkg.sv
package trig_busy_pkg;
  parameter int unsigned DLY_W_DEF   = 9;
  parameter int unsigned MAX_DLY_DEF = 500;
  parameter int unsigned EXT_W_DEF   = 5;

  // Effective delay tap: requests beyond the line length use the last stage.
  function automatic int unsigned clamp_tap(input int unsigned req, input int unsigned lim);
    return (req > lim) ? lim : req;
  endfunction

  // Rising-edge test between two successive level samples.
  function automatic logic lead_edge(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction
endpackage

// File: rtl/trig_src_sel.sv
module trig_src_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic src_a,
  input  logic src_b,
  input  logic use_a,
  output logic lvl,
  output logic pulse
);
  import trig_busy_pkg::*;

  logic lvl_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl      <= 1'b0;
      lvl_prev <= 1'b0;
    end else begin
      lvl      <= use_a ? src_a : src_b;
      lvl_prev <= lvl;
    end
  end

  assign pulse = lead_edge(lvl, lvl_prev);
endmodule

// File: rtl/busy_delay_line.sv
module busy_delay_line #(
  parameter int unsigned DLY_W   = trig_busy_pkg::DLY_W_DEF,
  parameter int unsigned MAX_DLY = trig_busy_pkg::MAX_DLY_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [DLY_W-1:0] dly_set,
  output logic             dout
);
  import trig_busy_pkg::*;

  localparam int unsigned IDX_W = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY + 1);

  generate
    if (MAX_DLY == 0) begin : g_bypass
      assign dout = din;
    end else if (MAX_DLY == 1) begin : g_single
      logic stage;
      always_ff @(posedge clk) begin
        if (!rst_n) stage <= 1'b0;
        else        stage <= din;
      end
      assign dout = (dly_set == '0) ? din : stage;
    end else begin : g_line
      logic [MAX_DLY-1:0] sr;
      logic [IDX_W-1:0]   tap;

      always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[MAX_DLY-2:0], din};
      end

      always_comb begin
        tap = IDX_W'(clamp_tap(int'(dly_set), MAX_DLY));
        if (tap == '0) dout = din;
        else           dout = sr[tap - 1'b1];
      end
    end
  endgenerate
endmodule

// File: rtl/busy_stretcher.sv
module busy_stretcher #(
  parameter int unsigned EXT_W = trig_busy_pkg::EXT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [EXT_W-1:0] ext_set,
  output logic             gate,
  output logic [EXT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (din)        cnt <= ext_set;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign gate = din | (cnt != '0);
endmodule

// File: rtl/trig_busy_gate.sv
module trig_busy_gate #(
  parameter int unsigned DLY_W   = trig_busy_pkg::DLY_W_DEF,
  parameter int unsigned MAX_DLY = trig_busy_pkg::MAX_DLY_DEF,
  parameter int unsigned EXT_W   = trig_busy_pkg::EXT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_lvds,
  input  logic             src_nim,
  input  logic             sel_lvds,
  input  logic [DLY_W-1:0] dly_set,
  input  logic [EXT_W-1:0] ext_set,
  output logic             trig_pulse,
  output logic             busy_gate
);
  // Named internal events, visible to the bound checker.
  logic             busy_lvl;
  logic             delayed_busy;
  logic [EXT_W-1:0] stretch_cnt;

  trig_src_sel u_src (
    .clk   (clk),
    .rst_n (rst_n),
    .src_a (src_lvds),
    .src_b (src_nim),
    .use_a (sel_lvds),
    .lvl   (busy_lvl),
    .pulse (trig_pulse)
  );

  busy_delay_line #(.DLY_W(DLY_W), .MAX_DLY(MAX_DLY)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (busy_lvl),
    .dly_set (dly_set),
    .dout    (delayed_busy)
  );

  busy_stretcher #(.EXT_W(EXT_W)) u_ext (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (delayed_busy),
    .ext_set (ext_set),
    .gate    (busy_gate),
    .cnt     (stretch_cnt)
  );
endmodule

// File: rtl/trig_busy_gate_chk.sv
module trig_busy_gate_chk #(
  parameter int unsigned DLY_W = 9,
  parameter int unsigned EXT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             src_lvds,
  input logic             src_nim,
  input logic             sel_lvds,
  input logic [DLY_W-1:0] dly_set,
  input logic [EXT_W-1:0] ext_set,
  input logic             trig_pulse,
  input logic             busy_gate,
  input logic             busy_lvl,
  input logic             delayed_busy,
  input logic [EXT_W-1:0] stretch_cnt
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1 / R6: the level register holds the selected source of the previous cycle
  assert_level_from_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (busy_lvl == $past(sel_lvds ? src_lvds : src_nim)));

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  // R3: with no delay, a trigger pulse finds the gate already open
  assert_zero_delay_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && dly_set == '0) |-> busy_gate);

  // R5: the gate outlives the delayed level when an extension is set
  assert_tail_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(delayed_busy) && ext_set != '0 && $stable(ext_set)) |-> busy_gate);

  // R5: a running tail counts down by one while the delayed level is low
  assert_tail_decrements_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!delayed_busy && stretch_cnt != '0) |=> (stretch_cnt == $past(stretch_cnt) - 1'b1));

  // R7: the gate cannot open before the level register has been set
  assert_gate_needs_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!past_ok) |-> !busy_gate);
endmodule

bind trig_busy_gate trig_busy_gate_chk #(.DLY_W(DLY_W), .EXT_W(EXT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_lvds     (src_lvds),
  .src_nim      (src_nim),
  .sel_lvds     (sel_lvds),
  .dly_set      (dly_set),
  .ext_set      (ext_set),
  .trig_pulse   (trig_pulse),
  .busy_gate    (busy_gate),
  .busy_lvl     (busy_lvl),
  .delayed_busy (delayed_busy),
  .stretch_cnt  (stretch_cnt)
);

// File: tb/trig_busy_gate_test.sv
module trig_busy_gate_test;
  localparam int MAXD = 500;
  localparam int HN   = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_lvds = 1'b0;
  logic       src_nim = 1'b0;
  logic       sel_lvds = 1'b0;
  logic [8:0] dly_set = '0;
  logic [4:0] ext_set = '0;
  logic       trig_pulse;
  logic       busy_gate;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit hist [HN];

  always #4 clk = ~clk;

  trig_busy_gate uut (
    .clk(clk), .rst_n(rst_n), .src_lvds(src_lvds), .src_nim(src_nim),
    .sel_lvds(sel_lvds), .dly_set(dly_set), .ext_set(ext_set),
    .trig_pulse(trig_pulse), .busy_gate(busy_gate)
  );

  function automatic bit h(input int i);
    return (i < 1 || i >= HN) ? 1'b0 : hist[i];
  endfunction

  // Input patterns: long pulses on each source, different periods.
  function automatic bit pat_lvds(input int n);
    return (n % 90) < 40;
  endfunction
  function automatic bit pat_nim(input int n);
    return ((n % 70) >= 5) && ((n % 70) < 45);
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input int n);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%b expected=%b", req, n, act, exp);
    end
  endtask

  task automatic run_cfg(input int d, input int e, input bit sel);
    int deff, len;
    bit eg, ep;
    deff = (d > MAXD) ? MAXD : d;          // R4 clamp
    len  = deff + e + 260;
    for (int i = 0; i < HN; i++) hist[i] = 1'b0;
    @(negedge clk);
    rst_n    = 1'b0;
    sel_lvds = sel;
    dly_set  = 9'(d);
    ext_set  = 5'(e);
    src_lvds = 1'b1;
    src_nim  = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 reset pulse", trig_pulse, 1'b0, 0);
    check("R7 reset gate", busy_gate, 1'b0, 0);
    src_lvds = 1'b0;
    src_nim  = 1'b0;
    rst_n    = 1'b1;
    for (int n = 1; n <= len; n++) begin
      // inputs for edge n; unselected source keeps toggling (R6)
      src_lvds = pat_lvds(n);
      src_nim  = pat_nim(n);
      hist[n]  = sel ? src_lvds : src_nim;   // R1 sample
      @(posedge clk);
      #2;
      ep = h(n) & ~h(n-1);
      eg = 1'b0;
      for (int j = 0; j <= e; j++) eg = eg | h(n - deff - j);
      check((e == 0) ? "R2/R6 pulse" : "R2 pulse", trig_pulse, ep, n);
      if (e == 0) check((d > MAXD) ? "R4 clamp gate" : "R3 delay gate", busy_gate, eg, n);
      else        check((d > MAXD) ? "R4/R5 gate" : "R5 extend gate", busy_gate, eg, n);
      @(negedge clk);
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int dl [8];
    int el [4];
    int k;
    dl = '{0, 1, 2, 5, 64, 499, 500, 511};
    el = '{0, 1, 7, 31};
    k = 0;
    foreach (dl[a]) begin
      foreach (el[b]) begin
        run_cfg(dl[a], el[b], k[0]);
        k++;
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule